// File: doc/BRIEF.md
# Incremental ADC Conversion Sequencer

This block paces an incremental sigma-delta converter that digitises several multiplexed channels one after another. A loadable down counter runs on the modulator clock and counts the cycles of one conversion. When the count runs out, the block takes a new sample on the sample-and-hold. It clears the modulator and its decimation filter, and it stops the modulator clock. Each conversion then starts from a known, empty state, so every result depends only on its own held input.

The clear stays asserted after the sample-and-hold has returned to hold mode. This gives the held voltage a programmable number of cycles to settle. The release then passes through a short synchronizer stage. Once the clear drops, the gated clock enable rises and a one-cycle start strobe marks the first enabled cycle. The filter therefore integrates exactly the selected number of modulator cycles.

Top module: `iadc_conv_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `sample_hold`=1, `conv_reset`=1, `clk_enable`=0 and `conv_start`=0. The cycle in which `rst_n` is released is a sample cycle.
- R2: A sample cycle lasts exactly one clock period and follows the last enabled cycle directly. In it, `sample_hold`=1 (1 = sample, 0 = hold), `conv_reset`=1 and `clk_enable`=0.
- R3: After the sample cycle, `sample_hold`=0 and `conv_reset`=1 hold for D settle cycles plus `SYNC_STAGES` (default 2) release cycles, with `clk_enable`=0. D is `settle_sel` as captured at the clock edge that ends the sample cycle.
- R4: A `settle_sel` value of 0 selects the default settle length of 2 cycles.
- R5: After the clear is released, `clk_enable`=1 and `conv_reset`=0 for exactly N consecutive cycles. N is `count_sel` as captured at the clock edge that releases the clear.
- R6: `conv_start` is high for one cycle only, the first enabled cycle of each conversion.
- R7: A `count_sel` value of 0 gives N = 256.
- R8: A change of `count_sel` while the modulator runs does not change the current conversion. The change applies from the next conversion on.
- R9: Pulling `rst_n` low forces the R1 output values at once, without waiting for a clock edge.
- R10: `clk_enable` and `conv_reset` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| count_sel | input | 8 | Cycles per conversion (0 means 256) |
| settle_sel | input | 4 | Settle cycles after the hold edge (0 means 2) |
| sample_hold | output | 1 | 1 = sample, 0 = hold |
| conv_reset | output | 1 | Modulator and filter clear, active high |
| clk_enable | output | 1 | Gate for the modulator clock |
| conv_start | output | 1 | Strobe on the first enabled cycle |

## Verification
The bench walks whole conversions cycle by cycle. It covers the smallest count of 1, the wrapped count of 0 (256 cycles), the shortest settle of 1 and the default settle selected by 0. A counter that is off by one would give N±1 enabled cycles and move every following sample cycle. A design that treated 0 literally would hang or end the conversion at once. A design that re-read `count_sel` during a run would cut the current conversion short when the setting changes. The bench also pulls the system reset low in the middle of a clock period. A design with a synchronous reset would keep the clock enable high until the next edge.

// File: rtl/iadc_seq_pkg.sv
`timescale 1ns/1ps
package iadc_seq_pkg;
   typedef enum logic [1:0] {
      PH_RUN    = 2'd0,
      PH_SETTLE = 2'd1,
      PH_SYNC   = 2'd2
   } seq_phase_t;

   function automatic int unsigned full_count(input int unsigned width);
      return 32'd1 << width;
   endfunction
endpackage

// File: rtl/iadc_term_cnt.sv
`timescale 1ns/1ps
module iadc_term_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count_sel,
   output logic             zero_o,
   output logic             first_o
);
   localparam int LOAD_W = CNT_W + 1;
   localparam logic [LOAD_W-1:0] FULL = LOAD_W'(iadc_seq_pkg::full_count(CNT_W));

   logic [LOAD_W-1:0] cnt_q;
   logic [LOAD_W-1:0] len_q;
   logic [LOAD_W-1:0] load_val;

   always_comb begin
      if (count_sel == '0) load_val = FULL;
      else                 load_val = {1'b0, count_sel};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
         len_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o  = (cnt_q == '0);
   assign first_o = (cnt_q != '0) && (cnt_q == len_q);
endmodule

// File: rtl/iadc_release_tmr.sv
`timescale 1ns/1ps
module iadc_release_tmr #(
   parameter int SET_W          = 4,
   parameter int SETTLE_DEFAULT = 2,
   parameter int SYNC_STAGES    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             in_settle,
   input  logic             in_sync,
   input  logic [SET_W-1:0] settle_sel,
   output logic             settle_done,
   output logic             sync_done
);
   logic [SET_W-1:0]       scnt_q;
   logic [SET_W-1:0]       dly;
   logic [SYNC_STAGES-1:0] sr_q;
   logic                   release_lvl;

   always_comb begin
      if (settle_sel == '0) dly = SET_W'(SETTLE_DEFAULT);
      else                  dly = settle_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          scnt_q <= '0;
      else if (arm)                        scnt_q <= dly - 1'b1;
      else if (in_settle && scnt_q != '0)  scnt_q <= scnt_q - 1'b1;
   end

   assign settle_done = in_settle && (scnt_q == '0);
   assign release_lvl = settle_done || in_sync;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q[0] <= 1'b0;
            else        sr_q[0] <= release_lvl;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q[g] <= 1'b0;
            else        sr_q[g] <= in_sync && sr_q[g-1];
         end
      end
   end

   assign sync_done = in_sync && sr_q[SYNC_STAGES-1];
endmodule

// File: rtl/iadc_conv_seq.sv
`timescale 1ns/1ps
module iadc_conv_seq #(
   parameter int CNT_W          = 8,
   parameter int SET_W          = 4,
   parameter int SETTLE_DEFAULT = 2,
   parameter int SYNC_STAGES    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_sel,
   input  logic [SET_W-1:0] settle_sel,
   output logic             sample_hold,
   output logic             conv_reset,
   output logic             clk_enable,
   output logic             conv_start
);
   import iadc_seq_pkg::*;

   localparam int SET_MAX = (1 << SET_W) - 1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (SETTLE_DEFAULT < 1 || SETTLE_DEFAULT > SET_MAX) begin : g_bad_def
      $error("SETTLE_DEFAULT out of range for SET_W");
   end

   seq_phase_t phase_q, phase_d;
   logic zero, first, tc, load, settle_done, sync_done;
   logic running;

   assign running = (phase_q == PH_RUN);
   assign tc      = running && zero;
   assign load    = (phase_q == PH_SYNC) && sync_done;

   iadc_term_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .count_sel (count_sel),
      .zero_o    (zero),
      .first_o   (first)
   );

   iadc_release_tmr #(
      .SET_W          (SET_W),
      .SETTLE_DEFAULT (SETTLE_DEFAULT),
      .SYNC_STAGES    (SYNC_STAGES)
   ) u_rel (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (tc),
      .in_settle   (phase_q == PH_SETTLE),
      .in_sync     (phase_q == PH_SYNC),
      .settle_sel  (settle_sel),
      .settle_done (settle_done),
      .sync_done   (sync_done)
   );

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_RUN:    if (tc)          phase_d = PH_SETTLE;
         PH_SETTLE: if (settle_done) phase_d = PH_SYNC;
         PH_SYNC:   if (sync_done)   phase_d = PH_RUN;
         default:                    phase_d = PH_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_RUN;
      else        phase_q <= phase_d;
   end

   // rst_n low clears the counter to zero, so the outputs take the sample state at once
   assign sample_hold = tc;
   assign clk_enable  = running && !zero;
   assign conv_reset  = !clk_enable;
   assign conv_start  = running && first;
endmodule

// File: rtl/iadc_conv_seq_chk.sv
`timescale 1ns/1ps
module iadc_conv_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic sample_hold,
   input logic conv_reset,
   input logic clk_enable,
   input logic conv_start
);
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(clk_enable && conv_reset));

   p_sample_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_hold |=> !sample_hold);

   p_sample_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_hold |-> (conv_reset && !clk_enable));

   p_hold_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_hold |=> conv_reset);

   p_run_then_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_enable) |-> sample_hold);

   p_start_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_enable) |-> conv_start);

   p_start_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   p_release_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_reset) |-> clk_enable);
endmodule

bind iadc_conv_seq iadc_conv_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sample_hold (sample_hold),
   .conv_reset  (conv_reset),
   .clk_enable  (clk_enable),
   .conv_start  (conv_start)
);

// File: tb/tb_iadc_conv_seq.sv
`timescale 1ns/1ps
module tb_iadc_conv_seq;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] count_sel;
   logic [3:0] settle_sel;
   logic       sample_hold, conv_reset, clk_enable, conv_start;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   iadc_conv_seq dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .count_sel   (count_sel),
      .settle_sel  (settle_sel),
      .sample_hold (sample_hold),
      .conv_reset  (conv_reset),
      .clk_enable  (clk_enable),
      .conv_start  (conv_start)
   );

   // output vector order: {sample_hold, conv_reset, clk_enable, conv_start}
   task automatic chk(input string rq, input logic [3:0] exp);
      logic [3:0] act;
      act = {sample_hold, conv_reset, clk_enable, conv_start};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b t=%0t", rq, act, exp, $time);
      end
   endtask

   task automatic chk_excl();
      total++;
      if (clk_enable && conv_reset) begin
         bad++;
         $display("FAIL R10 act=en1,rst1 exp=not both t=%0t", $time);
      end
   endtask

   // entered in a sample cycle; returns in the next sample cycle
   task automatic walk(input int n, input int d, input string stag,
                       input string rtag, input int chg);
      chk("R2", 4'b1100);
      for (int i = 0; i < d + 2; i++) begin
         @(negedge clk);
         chk(stag, 4'b0100);
         chk_excl();
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk((i == 0) ? "R6" : rtag, {3'b001, (i == 0)});
         chk_excl();
         if (i == 0 && chg >= 0) count_sel = 8'(chg);
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; count_sel = 8'd5; settle_sel = 4'd3;
      repeat (3) @(negedge clk);
      chk("R1", 4'b1100);
      rst_n = 1'b1;
      walk(5, 3, "R3", "R5", -1);
   endtask

   task automatic t_minimum();
      count_sel = 8'd1; settle_sel = 4'd1;
      walk(1, 1, "R3", "R5", -1);
   endtask

   task automatic t_default_settle();
      count_sel = 8'd3; settle_sel = 4'd0;
      walk(3, 2, "R4", "R5", -1);
   endtask

   task automatic t_wrap_count();
      count_sel = 8'd0; settle_sel = 4'd1;
      walk(256, 1, "R3", "R7", -1);
   endtask

   task automatic t_midrun_change();
      count_sel = 8'd4; settle_sel = 4'd1;
      walk(4, 1, "R3", "R8", 9);
      walk(9, 1, "R3", "R8", -1);
   endtask

   task automatic t_async_reset();
      count_sel = 8'd6; settle_sel = 4'd2;
      repeat (7) @(negedge clk);
      chk("R5", 4'b0010);
      #2 rst_n = 1'b0;
      #1 chk("R9", 4'b1100);
      @(negedge clk);
      chk("R1", 4'b1100);
      rst_n = 1'b1;
      walk(6, 2, "R3", "R5", -1);
   endtask

   initial begin
      rst_n = 1'b0; count_sel = '0; settle_sel = '0;
      t_reset();
      t_minimum();
      t_default_settle();
      t_wrap_count();
      t_midrun_change();
      t_async_reset();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule